// File: doc/BRIEF.md
# Status Flag and Interrupt Aggregator

This block watches a set of live status levels coming from a power converter's control logic (regulation states, input power-good, temperature zone, clock-sync state, reverse-power mode, the conversion-done strobe of a measurement unit and six protection faults). It turns changes on those levels into sticky event flags. Each source has its own detection rule. Some flags latch when their condition is entered. Some latch on either edge of a one-bit status. Some latch on any change of a multi-bit status field.

A host reaches the flags and their mask bits through a simple register port. The host reads a flag register, and that read clears the flags it holds. A mask bit set to 1 silences the interrupt for its event, but the flag still latches, so the host can keep polling. Each unmasked event drives a low pulse of fixed, parameterised length on an active-low interrupt output.

Top module: `evt_flag_hub`

## Requirements
- R1: Entry flags latch on a 0-to-1 transition of their status and never on a 1-to-0 transition or a steady level. The entry flags are: in flag register A (address 0), bit1 input-current regulation, bit2 input-voltage regulation and bit3 watchdog expiry; and all fault flags in register F (address 2), bits 0..5 = fault_i[0..5]. A latched flag stays set until its register is read.
- R2: The power-good flag (register B, address 1, bit0) and the reverse-mode flag (register B bit1) latch on either edge of their status bit.
- R3: The change flags latch when their field takes any new value. These are: the converter-state flag (register A bit4), the temperature-zone flag (register B bit2) and the sync-state flag (register B bit3).
- R4: A read (rd_en_i high) of a flag register returns its flags on rdata_o in the cycle after the request, zero-extended to 8 bits. The same read clears all flags of that register.
- R5: An event detected in the same cycle as the read that clears its flag leaves that flag set afterwards. The read itself returns the value from before the event.
- R6: A mask bit of 1 stops its event from producing an interrupt pulse, while the flag still latches. The mask registers are M_A (address 4), M_B (address 5) and M_F (address 6), with bit positions equal to those of the flags.
- R7: Every unmasked event drives int_n_o low for exactly PULSE_LEN cycles, starting in the cycle after the event. An unmasked event during a pulse restarts the full length.
- R8: The conversion-done flag (register A bit0) latches on a rising adc_done_i only while one_shot_i is 1. While one_shot_i is 0, the flag is held at 0 and reads 0.
- R9: After reset, all flags and masks are 0 and int_n_o is 1. Levels already present when reset releases are not events.
- R10: The mask registers read back what was written, with unimplemented bits reading 0. Writes to flag addresses are ignored. Reads of addresses 3 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| one_shot_i | input | 1 | Measurement unit in one-shot mode |
| adc_done_i | input | 1 | Conversion complete status |
| icl_reg_i | input | 1 | In input-current regulation |
| vin_reg_i | input | 1 | In input-voltage regulation |
| wdt_exp_i | input | 1 | Host watchdog expired status |
| conv_state_i | input | CONV_W | Converter state field |
| pwr_good_i | input | 1 | Input power good |
| temp_zone_i | input | ZONE_W | Temperature zone field |
| rev_on_i | input | 1 | Reverse-power mode active |
| sync_state_i | input | SYNC_W | Sync pin state field |
| fault_i | input | NUM_FAULTS | Protection fault levels |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_en_i |
| int_n_o | output | 1 | Active-low interrupt pulse |

## Verification
The bench targets a read that lands in the same cycle as a new event. A design that cleared first would lose that event. It checks falling edges of entry sources, which a design using change detection would wrongly flag. It checks both edges of the toggle sources, which a design using rising-edge detection would miss half of. It checks that masked faults still latch: a design that gated the flag with the mask would break polling. It also checks the restart of a pulse already running and the continuous-mode suppression of the conversion-done flag, which an extra or shortened interrupt would reveal.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;

    typedef enum logic [0:0] {
        DET_ENTRY  = 1'b0,
        DET_CHANGE = 1'b1
    } det_kind_e;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int GA_W   = 5;
    localparam int GB_W   = 4;

    localparam logic [ADDR_W-1:0] A_FLAG_A = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAG_B = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAG_F = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_A = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK_B = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK_F = 3'd6;

    typedef struct packed {
        logic rd_a;
        logic rd_b;
        logic rd_f;
        logic wr_a;
        logic wr_b;
        logic wr_f;
    } reg_hit_t;

    function automatic reg_hit_t decode_hit(input logic rd, input logic wr,
                                            input logic [ADDR_W-1:0] addr);
        reg_hit_t h;
        h.rd_a = rd && (addr == A_FLAG_A);
        h.rd_b = rd && (addr == A_FLAG_B);
        h.rd_f = rd && (addr == A_FLAG_F);
        h.wr_a = wr && (addr == A_MASK_A);
        h.wr_b = wr && (addr == A_MASK_B);
        h.wr_f = wr && (addr == A_MASK_F);
        return h;
    endfunction

endpackage

// File: rtl/evt_detect.sv
module evt_detect
    import evt_flag_pkg::*;
#(
    parameter int        W    = 1,
    parameter det_kind_e KIND = DET_ENTRY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_i,
    input  logic [W-1:0] sig_i,
    output logic         evt_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    generate
        if (KIND == DET_ENTRY) begin : g_entry
            assign evt_o = arm_i && |(sig_i & ~prev_q);
        end else begin : g_change
            assign evt_o = arm_i && (sig_i != prev_q);
        end
    endgenerate

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic [W-1:0] hold_clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_d_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] mask_o,
    output logic         fire_o
);

    logic [W-1:0] flag_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] kept;

    // A read clears old flags; an event in that cycle survives it.
    assign kept = clr_i ? '0 : flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= (kept | evt_i) & ~hold_clr_i;
            if (mask_we_i) mask_q <= mask_d_i;
        end
    end

    assign fire_o = |(evt_i & ~mask_q);
    assign flag_o = flag_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/int_pulse.sv
module int_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic int_n_o
);

    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (trig_i)         cnt_q <= CNT_W'(LEN);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign int_n_o = (cnt_q == '0);

endmodule

// File: rtl/evt_flag_hub.sv
module evt_flag_hub
    import evt_flag_pkg::*;
#(
    parameter int PULSE_LEN  = 4,
    parameter int CONV_W     = 3,
    parameter int ZONE_W     = 3,
    parameter int SYNC_W     = 2,
    parameter int NUM_FAULTS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  one_shot_i,
    input  logic                  adc_done_i,
    input  logic                  icl_reg_i,
    input  logic                  vin_reg_i,
    input  logic                  wdt_exp_i,
    input  logic [CONV_W-1:0]     conv_state_i,
    input  logic                  pwr_good_i,
    input  logic [ZONE_W-1:0]     temp_zone_i,
    input  logic                  rev_on_i,
    input  logic [SYNC_W-1:0]     sync_state_i,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic                  rd_en_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    output logic                  int_n_o
);

    localparam int GF_W = NUM_FAULTS;

    logic primed_q;
    logic ev_adc, ev_icl, ev_vin, ev_wdt, ev_conv;
    logic ev_pg, ev_rev, ev_zone, ev_sync;
    logic [GA_W-1:0] evt_a, flag_a, mask_a, hold_a;
    logic [GB_W-1:0] evt_b, flag_b, mask_b;
    logic [GF_W-1:0] evt_f, flag_f, mask_f;
    logic fire_a, fire_b, fire_f, fire;
    reg_hit_t hit;
    logic [REG_W-1:0] rd_mux, rdata_q;

    // First cycle after reset only samples the levels.
    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    evt_detect #(.W(1), .KIND(DET_ENTRY)) u_det_adc (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(adc_done_i), .evt_o(ev_adc));
    evt_detect #(.W(1), .KIND(DET_ENTRY)) u_det_icl (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(icl_reg_i), .evt_o(ev_icl));
    evt_detect #(.W(1), .KIND(DET_ENTRY)) u_det_vin (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(vin_reg_i), .evt_o(ev_vin));
    evt_detect #(.W(1), .KIND(DET_ENTRY)) u_det_wdt (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(wdt_exp_i), .evt_o(ev_wdt));
    evt_detect #(.W(CONV_W), .KIND(DET_CHANGE)) u_det_conv (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(conv_state_i), .evt_o(ev_conv));
    evt_detect #(.W(1), .KIND(DET_CHANGE)) u_det_pg (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(pwr_good_i), .evt_o(ev_pg));
    evt_detect #(.W(1), .KIND(DET_CHANGE)) u_det_rev (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(rev_on_i), .evt_o(ev_rev));
    evt_detect #(.W(ZONE_W), .KIND(DET_CHANGE)) u_det_zone (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(temp_zone_i), .evt_o(ev_zone));
    evt_detect #(.W(SYNC_W), .KIND(DET_CHANGE)) u_det_sync (
        .clk(clk), .rst(rst), .arm_i(primed_q), .sig_i(sync_state_i), .evt_o(ev_sync));

    generate
        for (genvar i = 0; i < GF_W; i++) begin : g_fault
            evt_detect #(.W(1), .KIND(DET_ENTRY)) u_det_flt (
                .clk(clk), .rst(rst), .arm_i(primed_q),
                .sig_i(fault_i[i]), .evt_o(evt_f[i]));
        end
    endgenerate

    assign evt_a  = {ev_conv, ev_wdt, ev_vin, ev_icl, ev_adc & one_shot_i};
    assign evt_b  = {ev_sync, ev_zone, ev_rev, ev_pg};
    assign hold_a = {{(GA_W-1){1'b0}}, ~one_shot_i};
    assign hit    = decode_hit(rd_en_i, wr_en_i, addr_i);

    flag_bank #(.W(GA_W)) u_bank_a (
        .clk(clk), .rst(rst), .evt_i(evt_a), .clr_i(hit.rd_a), .hold_clr_i(hold_a),
        .mask_we_i(hit.wr_a), .mask_d_i(wdata_i[GA_W-1:0]),
        .flag_o(flag_a), .mask_o(mask_a), .fire_o(fire_a));
    flag_bank #(.W(GB_W)) u_bank_b (
        .clk(clk), .rst(rst), .evt_i(evt_b), .clr_i(hit.rd_b), .hold_clr_i('0),
        .mask_we_i(hit.wr_b), .mask_d_i(wdata_i[GB_W-1:0]),
        .flag_o(flag_b), .mask_o(mask_b), .fire_o(fire_b));
    flag_bank #(.W(GF_W)) u_bank_f (
        .clk(clk), .rst(rst), .evt_i(evt_f), .clr_i(hit.rd_f), .hold_clr_i('0),
        .mask_we_i(hit.wr_f), .mask_d_i(wdata_i[GF_W-1:0]),
        .flag_o(flag_f), .mask_o(mask_f), .fire_o(fire_f));

    assign fire = fire_a | fire_b | fire_f;

    int_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .trig_i(fire), .int_n_o(int_n_o));

    always_comb begin
        rd_mux = '0;
        case (addr_i)
            A_FLAG_A: rd_mux = REG_W'(flag_a);
            A_FLAG_B: rd_mux = REG_W'(flag_b);
            A_FLAG_F: rd_mux = REG_W'(flag_f);
            A_MASK_A: rd_mux = REG_W'(mask_a);
            A_MASK_B: rd_mux = REG_W'(mask_b);
            A_MASK_F: rd_mux = REG_W'(mask_f);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/evt_flag_hub_chk.sv
module evt_flag_hub_chk
    import evt_flag_pkg::*;
#(
    parameter int NF = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              primed,
    input logic              one_shot_i,
    input logic              pwr_good_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic              int_n_o,
    input logic              fire,
    input logic [GA_W-1:0]   flag_a,
    input logic [GB_W-1:0]   flag_b,
    input logic [NF-1:0]     flag_f,
    input logic [NF-1:0]     evt_f,
    input logic [NF-1:0]     mask_f
);

    assert_fault_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && addr_i == A_FLAG_F) |=> (($past(flag_f) & ~flag_f) == '0));

    assert_pg_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        (primed && (pwr_good_i != $past(pwr_good_i))) |=> flag_b[0]);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == A_FLAG_F) |=> ((flag_f & ~$past(evt_f)) == '0));

    assert_event_survives_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == A_FLAG_F) |=> ((flag_f & $past(evt_f)) == $past(evt_f)));

    assert_silent_without_fire_R6: assert property (@(posedge clk) disable iff (rst)
        (!fire && int_n_o) |=> int_n_o);

    assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> !int_n_o);

    assert_continuous_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !one_shot_i |=> !flag_a[0]);

    assert_mask_readback_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == A_MASK_F) |=> (rdata_o == REG_W'($past(mask_f))));

endmodule

bind evt_flag_hub evt_flag_hub_chk #(.NF(NUM_FAULTS)) u_chk (
    .clk(clk), .rst(rst), .primed(primed_q), .one_shot_i(one_shot_i),
    .pwr_good_i(pwr_good_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .rdata_o(rdata_o), .int_n_o(int_n_o), .fire(fire),
    .flag_a(flag_a), .flag_b(flag_b), .flag_f(flag_f),
    .evt_f(evt_f), .mask_f(mask_f));

// File: tb/evt_flag_hub_bench.sv
module evt_flag_hub_bench;

    localparam int LEN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic one_shot, adc_done, icl, vin, wdt, pg, rev;
    logic [2:0] conv, zone;
    logic [1:0] sync;
    logic [5:0] fault;
    logic rd_en, wr_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic int_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [4:0] mfa, mma;
    logic [3:0] mfb, mmb;
    logic [5:0] mff, mmf;
    int mcnt;
    bit primed;
    logic p_adc, p_icl, p_vin, p_wdt, p_pg, p_rev;
    logic [2:0] p_conv, p_zone;
    logic [1:0] p_sync;
    logic [5:0] p_fault;
    logic [7:0] exp_rd;

    always #2.5 clk = ~clk;

    evt_flag_hub #(.PULSE_LEN(LEN)) u_evt_flag_hub (
        .clk(clk), .rst(rst), .one_shot_i(one_shot), .adc_done_i(adc_done),
        .icl_reg_i(icl), .vin_reg_i(vin), .wdt_exp_i(wdt), .conv_state_i(conv),
        .pwr_good_i(pg), .temp_zone_i(zone), .rev_on_i(rev), .sync_state_i(sync),
        .fault_i(fault), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .int_n_o(int_n));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {3'b0, mfa};
            3'd1: return {4'b0, mfb};
            3'd2: return {2'b0, mff};
            3'd4: return {3'b0, mma};
            3'd5: return {4'b0, mmb};
            3'd6: return {2'b0, mmf};
            default: return 8'h00;
        endcase
    endfunction

    task automatic tick();
        logic [4:0] ea;
        logic [3:0] eb;
        logic [5:0] ef;
        bit fire;
        ea = '0; eb = '0; ef = '0;
        if (primed) begin
            ea = {conv != p_conv, wdt & ~p_wdt, vin & ~p_vin, icl & ~p_icl,
                  adc_done & ~p_adc & one_shot};
            eb = {sync != p_sync, zone != p_zone, rev != p_rev, pg != p_pg};
            ef = fault & ~p_fault;
        end
        fire = |(ea & ~mma) || |(eb & ~mmb) || |(ef & ~mmf);
        if (rd_en) begin
            exp_rd = model_read(addr);
            if (addr == 3'd0) mfa = '0;
            if (addr == 3'd1) mfb = '0;
            if (addr == 3'd2) mff = '0;
        end
        if (wr_en) begin
            if (addr == 3'd4) mma = wdata[4:0];
            if (addr == 3'd5) mmb = wdata[3:0];
            if (addr == 3'd6) mmf = wdata[5:0];
        end
        mfa |= ea; mfb |= eb; mff |= ef;
        if (!one_shot) mfa[0] = 1'b0;
        mcnt = fire ? LEN : (mcnt > 0 ? mcnt - 1 : 0);
        p_adc = adc_done; p_icl = icl; p_vin = vin; p_wdt = wdt; p_pg = pg;
        p_rev = rev; p_conv = conv; p_zone = zone; p_sync = sync; p_fault = fault;
        primed = 1;
        @(posedge clk); #1;
        chk("R7 int_n", {7'b0, int_n}, {7'b0, mcnt == 0});
        if (rd_en) chk(addr >= 3'd4 ? "R10 mask read" : "R4 flag read", rdata, exp_rd);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        int lows;
        void'($urandom(32'd20240817));
        one_shot = 1; adc_done = 0; icl = 0; vin = 0; wdt = 0; pg = 0; rev = 0;
        conv = 0; zone = 0; sync = 0; fault = 6'h01;
        rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
        mfa = 0; mfb = 0; mff = 0; mma = 0; mmb = 0; mmf = 0; mcnt = 0; primed = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9: level present at release is not an event
        tick();
        chk("R9 int_n after reset", {7'b0, int_n}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R9 register zero after reset", v, 8'h00);
        end
        // R1: entry of fault bit2
        fault = 6'h05;
        tick();
        lows = (int_n == 1'b0) ? 1 : 0;
        for (int i = 0; i < LEN + 1; i++) begin
            tick();
            if (int_n == 1'b0) lows++;
        end
        chk("R7 pulse length", 8'(lows), 8'(LEN));
        rd(3'd2, v); chk("R1 fault entry flag", v, 8'h04);
        rd(3'd2, v); chk("R4 cleared after read", v, 8'h00);
        fault = 6'h01; tick();
        rd(3'd2, v); chk("R1 fault exit no flag", v, 8'h00);
        icl = 1; tick(); icl = 0; tick();
        rd(3'd0, v); chk("R1 regulation entry", v, 8'h02);
        // R2: power-good both edges
        pg = 1; tick();
        rd(3'd1, v); chk("R2 pg rise", v, 8'h01);
        pg = 0; tick();
        rd(3'd1, v); chk("R2 pg fall", v, 8'h01);
        // R3: field change
        zone = 3'd5; tick();
        rd(3'd1, v); chk("R3 zone change", v, 8'h04);
        zone = 3'd3; conv = 3'd4; tick();
        rd(3'd1, v); chk("R3 zone second change", v, 8'h04);
        rd(3'd0, v); chk("R3 conv change", v, 8'h10);
        // R5: event in the clearing read cycle
        rev = 1; rd(3'd1, v);
        chk("R5 read returns old value", v, 8'h00);
        rd(3'd1, v); chk("R5 event kept", v, 8'h02);
        // R6: masked fault still latches, no pulse
        wr(3'd6, 8'hFF);
        rd(3'd6, v); chk("R10 mask readback width", v, 8'h3F);
        repeat (LEN + 1) tick();
        fault = 6'h11; tick();
        lows = 0;
        for (int i = 0; i < LEN; i++) begin
            if (int_n == 1'b0) lows++;
            tick();
        end
        chk("R6 masked no pulse", 8'(lows), 8'h00);
        rd(3'd2, v); chk("R6 masked flag latched", v, 8'h10);
        wr(3'd6, 8'h00);
        // R8: continuous mode suppression
        one_shot = 0; adc_done = 1; tick(); adc_done = 0; tick();
        rd(3'd0, v); chk("R8 continuous reads zero", v, 8'h00);
        one_shot = 1; adc_done = 1; tick();
        rd(3'd0, v); chk("R8 one-shot latches", v, 8'h01);
        adc_done = 0; tick();
        // R10: flag writes ignored, empty addresses
        vin = 1; tick(); vin = 0;
        wr(3'd0, 8'hFF);
        rd(3'd0, v); chk("R10 flag write ignored", v, 8'h04);
        wr(3'd7, 8'hFF);
        rd(3'd7, v); chk("R10 empty address", v, 8'h00);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); chk("R10 mask A width", v, 8'h1F);
        wr(3'd4, 8'h00);
        // R7: restart during pulse
        repeat (LEN + 1) tick();
        wdt = 1; tick(); tick(); wdt = 0;
        pg = ~pg; tick();
        lows = 1;
        for (int i = 0; i < LEN + 1; i++) begin
            tick();
            if (int_n == 1'b0) lows++;
        end
        chk("R7 restart length", 8'(lows), 8'(LEN));
        // random phase, checked against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 15));
            case (r)
                0: icl = ~icl;
                1: vin = ~vin;
                2: pg = ~pg;
                3: rev = ~rev;
                4: zone = 3'($urandom);
                5: conv = 3'($urandom);
                6: sync = 2'($urandom);
                7: fault[$urandom_range(0, 5)] ^= 1'b1;
                8: adc_done = ~adc_done;
                9: wdt = ~wdt;
                default: ;
            endcase
            if ($urandom_range(0, 63) == 0) one_shot = ~one_shot;
            r = int'($urandom_range(0, 9));
            if (r < 2) rd(3'($urandom), v);
            else if (r == 2) wr(3'($urandom_range(4, 6)), 8'($urandom));
            else tick();
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule